// File: doc/BRIEF.md
# Processor Interrupt Request Gate

This block sits beside a processor core and decides whether the core should see a hard interrupt. Eight level-sensitive request lines are captured each clock into an 8-bit pending field, which the core reads as part of its cause register. A single request output is raised when at least one pending bit is also enabled in the eight-bit mask of the status word. The request is allowed only when the global enable is set, neither the exception-level nor the error-level flag is set, and the core is not in debug mode.

Pending bits and the request are registered on the same clock edge from the same sampled inputs. Both therefore follow the inputs with exactly one cycle of latency, and the request never shows a stale combination of pending bits and status bits. Nothing is latched on edges: the request stays high only while an unmasked line stays high. Vectoring, priority encoding, software writes to pending bits and exception entry belong to other blocks.

Top module: `irq_pending_gate`

## Requirements
- R1: While `rst` is high at a rising clock edge, that edge sets `pending` to 0 and `irq_req` to 0.
- R2: Bit n of `pending` equals bit n of `irq_lines` as sampled at the previous rising edge. A high line sets the bit and a low line clears it.
- R3: When `stat_ie` was 0 at the previous edge, `irq_req` is 0.
- R4: When `stat_exl` was 1 at the previous edge, `irq_req` is 0.
- R5: When `stat_erl` was 1 at the previous edge, `irq_req` is 0.
- R6: When `dbg_mode` was 1 at the previous edge, `irq_req` is 0 whatever the pending and mask bits are.
- R7: With all gating conditions met at the previous edge, `irq_req` is 1 exactly when the bitwise AND of `stat_mask` and `irq_lines` sampled at that edge is nonzero.
- R8: There is no edge latching. One cycle after the last unmasked line drops, or after its mask bit clears, `irq_req` returns to 0.
- R9: The mask and the gating bits have no effect on `pending`. A line that is masked or gated still shows in its pending bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_lines | input | 8 | Level interrupt request lines, already synchronous to `clk` |
| stat_ie | input | 1 | Global interrupt enable from the status word |
| stat_exl | input | 1 | Exception-level flag, blocks requests when 1 |
| stat_erl | input | 1 | Error-level flag, blocks requests when 1 |
| stat_mask | input | 8 | Per-line enable mask from the status word |
| dbg_mode | input | 1 | Core is in debug mode, blocks requests when 1 |
| pending | output | 8 | Registered pending field for the cause register |
| irq_req | output | 1 | Registered hard-interrupt request to the core |

## Verification
The hardest case to reach is the one where every gating term is open except one. Only then does a single failing term decide the output, and independent random stimulus seldom produces it. The random loop therefore opens each gating term with high probability, so lone blockers turn up often. Directed sequences then close exactly one term at a time while an unmasked line stays high. Other directed steps drop the last enabled line, or its mask bit, to show that the request falls one cycle later.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;

    localparam int IRQ_LINES = 8;

    // Gating fields taken from the status word plus the debug flag
    typedef struct packed {
        logic ie;
        logic exl;
        logic erl;
        logic dbg;
    } gate_t;

endpackage

// File: rtl/irq_line_capture.sv
module irq_line_capture #(
    parameter int N = irq_gate_pkg::IRQ_LINES
) (
    input  logic         rst,
    input  logic [N-1:0] lines_i,
    output logic [N-1:0] pend_d_o
);
    // One pending bit per line: follows the level, cleared by reset
    for (genvar i = 0; i < N; i++) begin : g_bit
        assign pend_d_o[i] = ~rst & lines_i[i];
    end
endmodule

// File: rtl/irq_status_qual.sv
module irq_status_qual
    import irq_gate_pkg::*;
(
    input  gate_t st_i,
    output logic  open_o
);
    always_comb begin
        open_o = st_i.ie & ~st_i.exl & ~st_i.erl & ~st_i.dbg;
    end
endmodule

// File: rtl/irq_mask_reduce.sv
module irq_mask_reduce #(
    parameter int N = irq_gate_pkg::IRQ_LINES
) (
    input  logic [N-1:0] mask_i,
    input  logic [N-1:0] pend_i,
    output logic         any_o
);
    logic [N-1:0] hit;
    for (genvar i = 0; i < N; i++) begin : g_and
        assign hit[i] = mask_i[i] & pend_i[i];
    end
    assign any_o = |hit;
endmodule

// File: rtl/irq_pending_gate.sv
module irq_pending_gate
    import irq_gate_pkg::*;
#(
    parameter int N = IRQ_LINES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] irq_lines,
    input  logic         stat_ie,
    input  logic         stat_exl,
    input  logic         stat_erl,
    input  logic [N-1:0] stat_mask,
    input  logic         dbg_mode,
    output logic [N-1:0] pending,
    output logic         irq_req
);
    typedef struct packed {
        logic [N-1:0] pend;
        logic         req;
    } state_t;

    state_t       st_d, st_q;
    gate_t        gate_w;
    logic [N-1:0] pend_d;
    logic         gate_open;
    logic         any_hit;

    assign gate_w = '{ie: stat_ie, exl: stat_exl, erl: stat_erl, dbg: dbg_mode};

    irq_line_capture #(.N(N)) u_cap (
        .rst      (rst),
        .lines_i  (irq_lines),
        .pend_d_o (pend_d)
    );

    irq_status_qual u_qual (
        .st_i   (gate_w),
        .open_o (gate_open)
    );

    irq_mask_reduce #(.N(N)) u_red (
        .mask_i (stat_mask),
        .pend_i (pend_d),
        .any_o  (any_hit)
    );

    // Next state: pending and request from the same sampled inputs
    always_comb begin
        st_d      = st_q;
        st_d.pend = pend_d;
        st_d.req  = ~rst & gate_open & any_hit;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign pending = st_q.pend;
    assign irq_req = st_q.req;

    // R1: reset clears everything
    a_r1_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (pending == '0 && !irq_req));

    // R2: pending tracks line levels with one cycle latency
    a_r2_pend_follow: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> pending == $past(irq_lines));

    // R3: global enable off blocks the request
    a_r3_ie_block: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(stat_ie)) |-> !irq_req);

    // R4: exception level blocks the request
    a_r4_exl_block: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(stat_exl)) |-> !irq_req);

    // R5: error level blocks the request
    a_r5_erl_block: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(stat_erl)) |-> !irq_req);

    // R6: debug mode blocks the request
    a_r6_dbg_block: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(dbg_mode)) |-> !irq_req);

    // R7: open gates pass masked pending through
    a_r7_open_pass: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(stat_ie) && !$past(stat_exl) && !$past(stat_erl)
         && !$past(dbg_mode)) |-> irq_req == |($past(stat_mask) & $past(irq_lines)));

    // R8: no latching once every unmasked line is low
    a_r8_no_latch: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && (($past(stat_mask) & $past(irq_lines)) == '0)) |-> !irq_req);

    // R9: a request implies some pending bit is set
    a_r9_req_has_pend: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> pending != '0);

endmodule

// File: tb/tb_irq_pending_gate.sv
module tb_irq_pending_gate;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] irq_lines = '0;
    logic         stat_ie = 1'b0, stat_exl = 1'b0, stat_erl = 1'b0, dbg_mode = 1'b0;
    logic [N-1:0] stat_mask = '0;
    logic [N-1:0] pending;
    logic         irq_req;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    irq_pending_gate #(.N(N)) dut (
        .clk(clk), .rst(rst), .irq_lines(irq_lines),
        .stat_ie(stat_ie), .stat_exl(stat_exl), .stat_erl(stat_erl),
        .stat_mask(stat_mask), .dbg_mode(dbg_mode),
        .pending(pending), .irq_req(irq_req)
    );

    function automatic logic exp_req(logic ie, logic exl, logic erl, logic dbg,
                                     logic [N-1:0] m, logic [N-1:0] l);
        return ie && !exl && !erl && !dbg && ((m & l) != '0);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive a set of inputs after a falling edge, let one rising edge pass,
    // then compare at the following falling edge
    task automatic step(logic [N-1:0] l, logic ie, logic exl, logic erl,
                        logic [N-1:0] m, logic dbg, string tag);
        irq_lines = l; stat_ie = ie; stat_exl = exl; stat_erl = erl;
        stat_mask = m; dbg_mode = dbg;
        @(posedge clk);
        @(negedge clk);
        chk({tag, " pending"}, 32'(pending), 32'(l));
        chk({tag, " irq_req"}, 32'(irq_req), 32'(exp_req(ie, exl, erl, dbg, m, l)));
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog actual=%0d expected<=50000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        // R1: reset with everything asserted
        irq_lines = '1; stat_ie = 1; stat_mask = '1;
        repeat (3) @(negedge clk);
        chk("R1 pending", 32'(pending), 0);
        chk("R1 irq_req", 32'(irq_req), 0);
        rst = 1'b0;

        // R2: single lines set and clear
        step(8'h01, 1, 0, 0, 8'hFF, 0, "R2 bit0");
        step(8'h80, 1, 0, 0, 8'hFF, 0, "R2 bit7");
        step(8'h00, 1, 0, 0, 8'hFF, 0, "R2 clear");
        // R3 to R6: one blocker at a time with an unmasked line high
        step(8'h10, 0, 0, 0, 8'h10, 0, "R3 ie off");
        step(8'h10, 1, 1, 0, 8'h10, 0, "R4 exl");
        step(8'h10, 1, 0, 1, 8'h10, 0, "R5 erl");
        step(8'h10, 1, 0, 0, 8'h10, 1, "R6 debug");
        // R7: open gates
        step(8'h10, 1, 0, 0, 8'h10, 0, "R7 open hit");
        step(8'h0F, 1, 0, 0, 8'hF0, 0, "R7 disjoint");
        step(8'h24, 1, 0, 0, 8'h04, 0, "R7 partial");
        // R8: drop line, then drop mask
        step(8'h00, 1, 0, 0, 8'h04, 0, "R8 line drop");
        step(8'h04, 1, 0, 0, 8'h04, 0, "R8 re-raise");
        step(8'h04, 1, 0, 0, 8'h00, 0, "R8 mask drop");
        // R9: mask and gates leave pending alone
        step(8'hA5, 0, 1, 1, 8'h00, 1, "R9 gated");
        step(8'h5A, 1, 0, 0, 8'h00, 0, "R9 masked");

        // Random mix biased towards open gates
        for (int i = 0; i < 400; i++) begin
            logic [N-1:0] l, m;
            logic ie, exl, erl, dbg;
            l   = N'($urandom);
            m   = N'($urandom);
            ie  = ($urandom % 5) != 0;
            exl = ($urandom % 5) == 0;
            erl = ($urandom % 5) == 0;
            dbg = ($urandom % 6) == 0;
            step(l, ie, exl, erl, m, dbg, "R7 random");
        end

        // R1 again: mid-run reset
        irq_lines = '1; stat_ie = 1; stat_exl = 0; stat_erl = 0; dbg_mode = 0; stat_mask = '1;
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R1 midrun pending", 32'(pending), 0);
        chk("R1 midrun irq_req", 32'(irq_req), 0);
        rst = 1'b0;
        step(8'h02, 1, 0, 0, 8'h02, 0, "R7 after reset");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule